// File: doc/BRIEF.md
# Two-Stage Masked Interrupt Status Unit

This block collects six single-cycle event pulses from a data-processing engine and turns them into sticky status bits and a single interrupt line. Two independent masks are applied in sequence. The capture mask decides which events are recorded at all. The line mask decides which recorded events may raise the interrupt output.

Software reaches the three registers through a simple 32-bit port. A write is a one-cycle strobe with address and data. Read data is a combinational function of the address. A status bit is cleared by writing a one to its position. Writing back the value just read therefore acknowledges exactly the events that were seen. When the same bit is both raised and cleared in one cycle, the new event is kept, so no event is lost.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status, capture-mask and line-mask registers all read zero, and `irq_out` is low.
- R2: In any cycle, an event pulse on source i sets status bit i only if bit i of the capture mask is 1. The status register is at offset 0x04 and the capture mask at 0x08. The sources map to status bits as follows: bit 0 is transfer done, bit 1 is main-area DMA, bit 2 is spare-area DMA, bit 3 is ECC error, bit 4 is to-spare and bit 5 is to-main.
- R3: A status bit that is set stays set when its capture-mask bit is later cleared. It stays set until software clears it.
- R4: A write to offset 0x04 clears exactly the status bits written as 1. Bits written as 0 are left unchanged.
- R5: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq_out` is a register. It equals the OR over all bits of (status AND line mask) as they stood in the previous cycle. The line mask is at offset 0x0C. A status of zero therefore gives a low `irq_out` one cycle later.
- R7: A line mask of zero holds `irq_out` low for any status. A line mask of 0x1 lets only bit 0 (transfer done) raise the interrupt.
- R8: Bits 31:6 of every register read as zero, and written values in those bits are ignored. Addresses other than 0x04, 0x08 and 0x0C read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 marks the access as a write |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| event_pulse | input | 6 | One pulse input per event source |
| irq_out | output | 1 | Registered interrupt line |

## Verification
The capture path is swept over every capture mask against every event pattern. Each pair also gets its own line mask. This separates the effect of capture gating, which sets the status value, from line gating, which sets the interrupt one cycle later. The same sweep checks that the interrupt is still low in the cycle of capture, which exposes a missing or extra register stage. Directed cases follow. They cover a clear that races an event on the same bit and on a different bit, and a partial write-1 clear of a full status. They also cover a mask dropped after capture, the two line-mask extremes, and writes of all ones and of unmapped addresses to show that the upper bits and the decode are ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned NUM_SRC = 6;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned DATA_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CAP_MSK = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_LINE_MSK = 8'h0C;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_CAP_MSK,
        SEL_LINE_MSK
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_STATUS:   s = SEL_STATUS;
            OFS_CAP_MSK:  s = SEL_CAP_MSK;
            OFS_LINE_MSK: s = SEL_LINE_MSK;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wdata,
    output logic [N-1:0]      cap_msk_o,
    output logic [N-1:0]      line_msk_o,
    output logic [N-1:0]      clr_mask_o
);
    typedef struct packed {
        logic [N-1:0] cap_msk;
        logic [N-1:0] line_msk;
    } regs_t;

    regs_t    st_d, st_q;
    reg_sel_e sel;

    always_comb begin
        st_d       = st_q;
        sel        = decode_addr(addr);
        clr_mask_o = '0;
        if (wr_en) begin
            case (sel)
                SEL_CAP_MSK:  st_d.cap_msk  = wdata;
                SEL_LINE_MSK: st_d.line_msk = wdata;
                SEL_STATUS:   clr_mask_o    = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_msk_o  = st_q.cap_msk;
    assign line_msk_o = st_q.line_msk;

    AST_MASK_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q)); // R8
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int unsigned N = irqc_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] event_i,
    input  logic [N-1:0] cap_msk_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] status_o
);
    typedef struct packed {
        logic [N-1:0] bits;
    } stat_t;

    stat_t        st_d, st_q;
    logic [N-1:0] set_mask;
    logic [N-1:0] next_bits;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign set_mask[i]  = event_i[i] & cap_msk_i[i];
        assign next_bits[i] = set_mask[i] | (st_q.bits[i] & ~clr_i[i]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = next_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.bits;

    AST_SET_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.bits & ~$past(st_q.bits)) & ~$past(event_i & cap_msk_i)) == '0); // R2
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.bits & $past(event_i & cap_msk_i)) == $past(event_i & cap_msk_i)); // R5
    AST_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~st_q.bits & $past(st_q.bits)) & ~$past(clr_i)) == '0); // R4
endmodule

// File: rtl/irqc_line.sv
module irqc_line #(
    parameter int unsigned N = irqc_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status_i,
    input  logic [N-1:0] line_msk_i,
    output logic         irq_o
);
    typedef struct packed {
        logic irq;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(status_i & line_msk_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        status_i == '0 |=> !st_q.irq); // R6
    AST_IRQ_LINE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        line_msk_i == '0 |=> !st_q.irq); // R7
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned N  = NUM_SRC,
    parameter int unsigned DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [N-1:0]      event_pulse,
    output logic              irq_out
);
    logic [N-1:0] cap_msk, line_msk, clr_mask, status;
    logic         wr_en;
    logic         unused_wdata_hi;

    assign wr_en           = bus_valid & bus_write;
    assign unused_wdata_hi = ^bus_wdata[DW-1:N];

    irqc_regs #(.N(N)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (bus_addr),
        .wdata      (bus_wdata[N-1:0]),
        .cap_msk_o  (cap_msk),
        .line_msk_o (line_msk),
        .clr_mask_o (clr_mask)
    );

    irqc_status #(.N(N)) status_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_i   (event_pulse),
        .cap_msk_i (cap_msk),
        .clr_i     (clr_mask),
        .status_o  (status)
    );

    irqc_line #(.N(N)) line_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_i   (status),
        .line_msk_i (line_msk),
        .irq_o      (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        case (decode_addr(bus_addr))
            SEL_STATUS:   bus_rdata[N-1:0] = status;
            SEL_CAP_MSK:  bus_rdata[N-1:0] = cap_msk;
            SEL_LINE_MSK: bus_rdata[N-1:0] = line_msk;
            default: ;
        endcase
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (status & $past(status)) == $past(status)); // R3
endmodule

// File: tb/irq_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb_top;
    localparam logic [7:0] A_ST  = 8'h04;
    localparam logic [7:0] A_CAP = 8'h08;
    localparam logic [7:0] A_LIN = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  event_pulse = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_status_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .event_pulse(event_pulse), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [5:0] e);
        event_pulse = e;
        @(negedge clk);
        event_pulse = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rd(A_ST, v);  chk("R1 status", v, 0);
        rd(A_CAP, v); chk("R1 capmask", v, 0);
        rd(A_LIN, v); chk("R1 linemask", v, 0);
        chk("R1 irq", {31'b0, irq_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_ST, v); chk("R1 status after release", v, 0);

        for (int m = 0; m < 64; m++) begin
            for (int e = 0; e < 64; e++) begin
                int s;
                logic [5:0] exp_st;
                s = (m * 5 + e * 3) % 64;
                exp_st = 6'(m & e);
                wr(A_ST, 32'h3F);
                wr(A_CAP, 32'(m));
                wr(A_LIN, 32'(s));
                pulse(6'(e));
                rd(A_ST, v); chk("R2 capture sweep", v, {26'b0, exp_st});
                chk("R6 irq lag", {31'b0, irq_out}, 0);
                @(negedge clk);
                chk("R6 irq sweep", {31'b0, irq_out}, {31'b0, |(exp_st & 6'(s))});
            end
        end

        wr(A_ST, 32'h3F);
        wr(A_CAP, 32'h01);
        pulse(6'h01);
        wr(A_CAP, 32'h00);
        pulse(6'h01);
        rd(A_ST, v); chk("R3 sticky after mask drop", v, 32'h01);

        wr(A_CAP, 32'h3F);
        pulse(6'h3F);
        wr(A_ST, 32'h05);
        rd(A_ST, v); chk("R4 partial clear", v, 32'h3A);
        wr(A_ST, 32'h3A);
        rd(A_ST, v); chk("R4 clear by readback", v, 32'h00);

        pulse(6'h03);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = A_ST; bus_wdata = 32'h03;
        event_pulse = 6'h01;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; event_pulse = '0;
        rd(A_ST, v); chk("R5 set wins same bit", v, 32'h01);

        wr(A_ST, 32'h3F);
        pulse(6'h3F);
        wr(A_LIN, 32'h00);
        @(negedge clk);
        chk("R7 zero line mask", {31'b0, irq_out}, 0);
        wr(A_ST, 32'h01);
        wr(A_LIN, 32'h01);
        @(negedge clk);
        chk("R7 bit0 only, bit0 clear", {31'b0, irq_out}, 0);
        pulse(6'h01);
        @(negedge clk);
        chk("R7 bit0 only, bit0 set", {31'b0, irq_out}, 1);
        wr(A_ST, 32'h3F);
        chk("R6 irq one cycle after clear", {31'b0, irq_out}, 1);
        @(negedge clk);
        chk("R6 irq drops after clear", {31'b0, irq_out}, 0);

        wr(A_CAP, 32'hFFFF_FFFF);
        rd(A_CAP, v); chk("R8 capmask upper bits", v, 32'h3F);
        wr(A_LIN, 32'hFFFF_FFC0);
        rd(A_LIN, v); chk("R8 linemask upper only", v, 32'h00);
        pulse(6'h3F);
        rd(A_ST, v); chk("R8 status upper bits", v, 32'h3F);
        wr(A_ST, 32'hFFFF_FFC0);
        rd(A_ST, v); chk("R8 status clear upper ignored", v, 32'h3F);
        wr(8'h00, 32'h3F);
        wr(8'h10, 32'h3F);
        wr(8'h0D, 32'h3F);
        rd(A_ST, v);  chk("R8 unmapped write status", v, 32'h3F);
        rd(A_LIN, v); chk("R8 unmapped write linemask", v, 32'h00);
        rd(8'h00, v); chk("R8 unmapped read 0x00", v, 0);
        rd(8'h10, v); chk("R8 unmapped read 0x10", v, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule